// File: doc/BRIEF.md
# Cascaded 24-Bit Event Counter

This block counts transitions on an asynchronous event pin with two cascaded counters. A low 8-bit stage counts qualified pin edges. Each time its count equals its own compare value it wraps to zero and sends one carry pulse. A high 16-bit stage counts those carry pulses and nothing else. When the high count equals its compare value, the high stage clears to zero and raises an interrupt request for one cycle. Set the low compare value to FFh and the pair behaves as a 24-bit event counter whose interrupt fires every 256 × (high compare + 1) events.

The pin is synchronized into the system clock domain and edge-detected there. A two-bit selector chooses which transitions count. A gate-mode bit can make counting depend on a separate gate-enable level. A run input drives a two-state controller. State ST_IDLE holds both stages and the interrupt at zero. Transition START (run high) enters ST_COUNT, where qualified edges are counted. Transition STOP (run low) returns to ST_IDLE. The low stage's match never reaches the interrupt output.

Top module: `evt24_counter`

## Requirements
- R1: `edge_sel` selects which transitions count: 00 rising, 01 falling, 10 both, 11 none.
- R2: While `gate_mode` is 1 and `gate_en` is 0, edges on the pin have no effect on the counters. While `gate_mode` is 0, `gate_en` has no effect.
- R3: The pin passes through two synchronizer flops. A qualified pin change advances `cnt8` by one on the third rising clock edge after the change.
- R4: When a qualified edge is counted while `cnt8` equals `cmp8`, `cnt8` wraps to 0 and `carry8` is high for that one cycle.
- R5: With `cmp8` = FFh, one carry occurs per 256 counted events.
- R6: `cnt16` advances by exactly one per carry and changes at no other time, except when it clears.
- R7: A carry that arrives while `cnt16` equals `cmp16` clears `cnt16` to 0 and drives `irq` high for the single following cycle.
- R8: `irq` repeats on every later match, once per `cmp16`+1 carries.
- R9: After reset, and while the controller is in ST_IDLE, `cnt8`, `cnt16` and `irq` are 0. The controller follows `run` one cycle later, and counting restarts from 0.
- R10: `count24` equals `cnt16` in bits 23:8 and `cnt8` in bits 7:0.
- R11: A low-stage match alone never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pin | input | 1 | Asynchronous external event input |
| edge_sel | input | 2 | Counted transition select |
| gate_mode | input | 1 | 1: counting requires gate_en |
| gate_en | input | 1 | Gate-enable level |
| cmp8 | input | 8 | Low-stage compare value |
| cmp16 | input | 16 | High-stage compare value |
| run | input | 1 | Run control |
| cnt8 | output | 8 | Low-stage count |
| cnt16 | output | 16 | High-stage count |
| count24 | output | 24 | Combined count |
| carry8 | output | 1 | Low-stage carry pulse |
| irq | output | 1 | High-stage match interrupt pulse |

## Verification
The hardest condition to reach from the ports is a high-stage match in true 24-bit use. With `cmp8` at FFh, each high-stage step needs 256 qualified events, and every one of them must pass the synchronizer. The random phase therefore keeps `cmp8` and `cmp16` small, so that wraps, carries and interrupts occur often alongside changes to gating, edge selection and run. A directed phase then sets `cmp8` to FFh and the edge select to both, and toggles the pin every cycle. This produces one event per clock and drives the cascade through several full periodic interrupts.

// File: rtl/evt24_pkg.sv
package evt24_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

endpackage

// File: rtl/evt24_edge_qual.sv
module evt24_edge_qual
    import evt24_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e sel,
    input  logic      gate_mode,
    input  logic      gate_en,
    output logic      step
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          rise, fall, hit, gate_ok;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[LAST-1:0], pin};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    always_comb begin
        rise    = sync_q[LAST] & ~prev_q;
        fall    = ~sync_q[LAST] & prev_q;
        gate_ok = ~gate_mode | gate_en;
        unique case (sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            EDGE_NONE: hit = 1'b0;
        endcase
        step = hit & gate_ok;
    end
endmodule

// File: rtl/evt24_low_stage.sv
module evt24_low_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         carry
);
    logic at_cmp;

    always_comb begin
        at_cmp = (cnt == cmp);
        carry  = step & at_cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (step)   cnt <= at_cmp ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/evt24_high_stage.sv
module evt24_high_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         irq
);
    logic at_cmp;

    always_comb at_cmp = (cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else if (clear) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= tick & at_cmp;
            if (tick) cnt <= at_cmp ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/evt24_counter.sv
module evt24_counter
    import evt24_pkg::*;
#(
    parameter int LO_W        = 8,
    parameter int HI_W        = 16,
    parameter int SYNC_STAGES = 2,
    localparam int TOT_W      = LO_W + HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_pin,
    input  logic [1:0]       edge_sel,
    input  logic             gate_mode,
    input  logic             gate_en,
    input  logic [LO_W-1:0]  cmp8,
    input  logic [HI_W-1:0]  cmp16,
    input  logic             run,
    output logic [LO_W-1:0]  cnt8,
    output logic [HI_W-1:0]  cnt16,
    output logic [TOT_W-1:0] count24,
    output logic             carry8,
    output logic             irq
);
    run_state_e state_q, state_d;
    logic       clear_all, count_ok, evt_step, lo_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run)  state_d = ST_COUNT;  // START
            ST_COUNT: if (!run) state_d = ST_IDLE;   // STOP
        endcase
    end

    always_comb begin
        clear_all = 1'b0;
        count_ok  = 1'b0;
        unique case (state_q)
            ST_IDLE:  clear_all = 1'b1;
            ST_COUNT: count_ok  = 1'b1;
        endcase
        lo_step = evt_step & count_ok;
    end

    evt24_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (evt_pin),
        .sel       (edge_sel_e'(edge_sel)),
        .gate_mode (gate_mode),
        .gate_en   (gate_en),
        .step      (evt_step)
    );

    evt24_low_stage #(.W(LO_W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_all),
        .step  (lo_step),
        .cmp   (cmp8),
        .cnt   (cnt8),
        .carry (carry8)
    );

    evt24_high_stage #(.W(HI_W)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_all),
        .tick  (carry8),
        .cmp   (cmp16),
        .cnt   (cnt16),
        .irq   (irq)
    );

    assign count24 = {cnt16, cnt8};
endmodule

// File: rtl/evt24_counter_chk.sv
module evt24_counter_chk #(
    parameter int LO_W = 8,
    parameter int HI_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            carry8,
    input logic [LO_W-1:0] cnt8,
    input logic [HI_W-1:0] cnt16,
    input logic            irq
);
    // R3
    lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt8 != $past(cnt8)) |-> ((cnt8 == $past(cnt8) + 1'b1) || (cnt8 == '0)));

    // R4
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry8 |=> (cnt8 == '0));

    // R6
    hi_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt16 != $past(cnt16)) |-> ($past(carry8) || (cnt16 == '0)));

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((cnt16 == '0) && $past(carry8)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run, 2) |-> ((cnt8 == '0) && (cnt16 == '0) && !irq));
endmodule

bind evt24_counter evt24_counter_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .carry8 (carry8),
    .cnt8   (cnt8),
    .cnt16  (cnt16),
    .irq    (irq)
);

// File: tb/evt24_counter_test.sv
module evt24_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pin = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        gate_mode = 1'b0;
    logic        gate_en = 1'b0;
    logic [7:0]  cmp8 = 8'd3;
    logic [15:0] cmp16 = 16'd2;
    logic        run = 1'b0;
    logic [7:0]  cnt8;
    logic [15:0] cnt16;
    logic [23:0] count24;
    logic        carry8, irq;

    int n_vec = 0, n_bad = 0;

    always #4 clk = ~clk;

    evt24_counter uut (
        .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .edge_sel(edge_sel),
        .gate_mode(gate_mode), .gate_en(gate_en), .cmp8(cmp8), .cmp16(cmp16),
        .run(run), .cnt8(cnt8), .cnt16(cnt16), .count24(count24),
        .carry8(carry8), .irq(irq)
    );

    // Reference model built from the requirements
    logic        s1_m, s2_m, p_m, st_m, irq_m;
    logic [7:0]  m8;
    logic [15:0] m16;

    function automatic logic edge_hit(logic cur, logic old, logic [1:0] sel);
        case (sel)
            2'b00:   return cur & ~old;   // R1 rising
            2'b01:   return ~cur & old;   // R1 falling
            2'b10:   return cur ^ old;    // R1 both
            default: return 1'b0;         // R1 none
        endcase
    endfunction

    function automatic logic model_step();
        return st_m && edge_hit(s2_m, p_m, edge_sel) && (!gate_mode || gate_en);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_m <= 0; s2_m <= 0; p_m <= 0; st_m <= 0; irq_m <= 0; m8 <= 0; m16 <= 0;
        end else begin
            s1_m <= evt_pin; s2_m <= s1_m; p_m <= s2_m; st_m <= run;
            if (!st_m) begin
                m8 <= 0; m16 <= 0; irq_m <= 0;
            end else begin
                irq_m <= 0;
                if (model_step()) begin
                    if (m8 == cmp8) begin
                        m8 <= 0;
                        if (m16 == cmp16) begin m16 <= 0; irq_m <= 1; end
                        else m16 <= m16 + 1;
                    end else m8 <= m8 + 1;
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int irq_dut = 0, irq_ref = 0;

    task automatic step();
        @(negedge clk); #1;
        chk("R3 cnt8", cnt8, m8);
        chk("R6 cnt16", cnt16, m16);
        chk("R7 irq", irq, irq_m);
        chk("R4 carry8", carry8, model_step() && (m8 == cmp8));
        chk("R10 count24", count24, {m16, m8});
        if (irq) irq_dut++;
        if (irq_m) irq_ref++;
    endtask

    logic [7:0] held;

    initial begin
        void'($urandom(32'd20240611));
        step(); step();
        // R9 reset state
        chk("R9 reset cnt8", cnt8, 0);
        chk("R9 reset irq", irq, 0);
        rst_n = 1'b1;
        run = 1'b1;
        step(); step();
        // R1 none: toggles ignored
        edge_sel = 2'b11;
        held = cnt8;
        for (int i = 0; i < 10; i++) begin step(); evt_pin = ~evt_pin; end
        step(); step(); step();
        chk("R1 edge none", cnt8, held);
        // R2 gate blocks events
        edge_sel = 2'b10; gate_mode = 1'b1; gate_en = 1'b0;
        held = cnt8;
        for (int i = 0; i < 10; i++) begin step(); evt_pin = ~evt_pin; end
        step(); step(); step();
        chk("R2 gated", cnt8, held);
        gate_en = 1'b1;
        // R3 latency: rising change counted on third edge
        edge_sel = 2'b00; cmp8 = 8'd200; evt_pin = 1'b0;
        step(); step(); step();
        held = cnt8;
        evt_pin = 1'b1;
        step(); chk("R3 edge1", cnt8, held);
        step(); chk("R3 edge2", cnt8, held);
        step(); chk("R3 edge3", cnt8, held + 8'd1);
        // Random phase
        for (int i = 0; i < 20000; i++) begin
            step();
            if ($urandom % 3 == 0)    evt_pin = ~evt_pin;
            if ($urandom % 200 == 0)  edge_sel = 2'($urandom);
            if ($urandom % 50 == 0)   gate_en = 1'($urandom);
            if ($urandom % 300 == 0)  gate_mode = 1'($urandom);
            if ($urandom % 500 == 0)  run = ($urandom % 4) != 0;
            if ($urandom % 1500 == 0) begin
                cmp8 = 8'($urandom % 8);
                cmp16 = 16'($urandom % 4);
            end
        end
        // R5 / R8 / R11 true 24-bit operation
        run = 1'b0; gate_mode = 1'b0; edge_sel = 2'b10;
        cmp8 = 8'hFF; cmp16 = 16'd2;
        step(); step(); step();
        chk("R9 idle", count24, 0);
        run = 1'b1;
        irq_dut = 0; irq_ref = 0;
        for (int i = 0; i < 600; i++) begin step(); evt_pin = ~evt_pin; end
        chk("R11 no irq before high match", irq_dut, 0);
        chk("R5 one carry per 256", cnt16, 16'd2);
        for (int i = 0; i < 1000; i++) begin step(); evt_pin = ~evt_pin; end
        chk("R8 periodic irq", irq_dut, 2);
        chk("R8 model agreement", irq_dut, irq_ref);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule